// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a 32-bit processor that retires one instruction on every rising clock edge. It covers a small three-operand load/store instruction subset: register and immediate arithmetic, bitwise logic, logical shifts, word loads and stores, two compare-and-branch forms, a call that saves its return address, and a return through a register. Instructions come from an internal word array. That array is filled through a write port while the core is held in reset. Data lives in a second internal word array.

For observation, the core offers three views. The program counter is a port. One combinational read port shows any entry of the 32-entry register file. A second combinational read port shows any data word. A test program usually ends in a branch to itself, which parks the program counter. The final state is then read through the two observation ports.

Top module: `onecyc_core`

## Requirements
- R1: While rst_n is low, the program counter is 0, every register reads 0, and the instruction array accepts writes (imem_we, word index imem_waddr). The first instruction executes at the first rising edge after rst_n goes high.
- R2: Opcode 0 selects the register form. Its fields are op[31:26], rs[25:21], rt[20:16], rd[15:11], shift[10:6] and fn[5:0]. Function codes 0x20 (add), 0x22 (rs minus rt), 0x24 (and) and 0x25 (or) write the result to rd, with wrap-around arithmetic.
- R3: Function 0x00 shifts rt left and function 0x02 shifts rt right, both logical and both by shift[10:6]. The result goes to rd.
- R4: Immediate forms use op, rs, rt and imm[15:0]. Opcode 0x08 writes rs plus the sign-extended imm to rt. Opcode 0x0C writes rs AND the zero-extended imm to rt.
- R5: Opcodes 0x23 (load) and 0x2B (store) form the byte address rs + sign-extended imm. Bits [DMEM_AW+1:2] of that address select the data word. A load writes that word to rt. A store writes rt to that word, and the word can then be read on dbg_mem_val.
- R6: Opcode 0x04 branches when rs equals rt, and opcode 0x05 branches when they differ. A taken branch sets the PC to PC + 4 + 4 × sign-extended imm. A branch that is not taken sets the PC to PC + 4.
- R7: Opcode 0x03 writes PC + 4 into register 31. It sets the PC to {(PC+4)[31:28], target[25:0], 2'b00}.
- R8: Register-form function 0x08 sets the PC to the value of rs.
- R9: Register 0 always reads as 0, and writes to it are discarded.
- R10: An opcode or register-form function outside this list changes no register and no data word, and only advances the PC by 4.
- R11: Each instruction completes in one clock. Every instruction that does not transfer control advances the PC by exactly 4 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_we | input | 1 | Write strobe for the instruction array |
| imem_waddr | input | IMEM_AW | Word index of the instruction being loaded |
| imem_wdata | input | 32 | Instruction word being loaded |
| pc_o | output | 32 | Current program counter (byte address) |
| dbg_reg_sel | input | 5 | Register index to observe |
| dbg_reg_val | output | 32 | Value of the selected register |
| dbg_mem_sel | input | DMEM_AW | Data word index to observe |
| dbg_mem_val | output | 32 | Value of the selected data word |

## Verification
A wrong next-PC choice shows on pc_o at the very next edge. After that, the instruction stream is out of step, and the damage grows until the parked program counter lands somewhere other than expected. A wrong datapath result, such as an operand sign-extended the wrong way, the wrong shift source, or a write-back that lands in the wrong register, stays hidden until the register or data word is read out. The bench therefore runs each short program to its parking branch, then reads every destination register. It also steps pc_o edge by edge through the jump and straight-line sequences.

// File: rtl/onecyc_pkg.sv
package onecyc_pkg;

  localparam int unsigned XLEN    = 32;
  localparam int unsigned REG_AW  = 5;

  localparam logic [5:0] OPC_REGFORM = 6'h00;
  localparam logic [5:0] OPC_CALL    = 6'h03;
  localparam logic [5:0] OPC_BR_EQ   = 6'h04;
  localparam logic [5:0] OPC_BR_NE   = 6'h05;
  localparam logic [5:0] OPC_ADD_IMM = 6'h08;
  localparam logic [5:0] OPC_AND_IMM = 6'h0C;
  localparam logic [5:0] OPC_LOAD    = 6'h23;
  localparam logic [5:0] OPC_STORE   = 6'h2B;

  localparam logic [5:0] FN_SHL = 6'h00;
  localparam logic [5:0] FN_SHR = 6'h02;
  localparam logic [5:0] FN_RET = 6'h08;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;

  localparam logic [REG_AW-1:0] LINK_REG = 5'd31;

  typedef enum logic [2:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_SHL, K_SHR
  } calc_e;

  typedef enum logic [1:0] {
    WR_TO_RD, WR_TO_RT, WR_TO_LINK
  } wsel_e;

  typedef struct packed {
    calc_e kind;
    logic  use_imm;
    logic  imm_unsigned;
    logic  reg_wr;
    wsel_e wsel;
    logic  ld;
    logic  st;
    logic  br_eq;
    logic  br_ne;
    logic  call;
    logic  ret;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] zext16(input logic [15:0] v);
    return {{(XLEN-16){1'b0}}, v};
  endfunction

  function automatic logic [XLEN-1:0] rel_dest(input logic [XLEN-1:0] seq,
                                               input logic [15:0] off);
    logic [XLEN-1:0] s;
    s = sext16(off);
    return seq + {s[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] abs_dest(input logic [XLEN-1:0] seq,
                                               input logic [25:0] tgt);
    return {seq[XLEN-1:28], tgt, 2'b00};
  endfunction

endpackage

// File: rtl/onecyc_decode.sv
module onecyc_decode
  import onecyc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] fn,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (op)
      OPC_REGFORM: begin
        unique case (fn)
          FN_ADD: begin ctrl.reg_wr = 1'b1; ctrl.kind = K_ADD; end
          FN_SUB: begin ctrl.reg_wr = 1'b1; ctrl.kind = K_SUB; end
          FN_AND: begin ctrl.reg_wr = 1'b1; ctrl.kind = K_AND; end
          FN_OR:  begin ctrl.reg_wr = 1'b1; ctrl.kind = K_OR;  end
          FN_SHL: begin ctrl.reg_wr = 1'b1; ctrl.kind = K_SHL; end
          FN_SHR: begin ctrl.reg_wr = 1'b1; ctrl.kind = K_SHR; end
          FN_RET: ctrl.ret = 1'b1;
          default: ;
        endcase
      end
      OPC_ADD_IMM: begin
        ctrl.reg_wr  = 1'b1;
        ctrl.wsel    = WR_TO_RT;
        ctrl.use_imm = 1'b1;
      end
      OPC_AND_IMM: begin
        ctrl.reg_wr       = 1'b1;
        ctrl.wsel         = WR_TO_RT;
        ctrl.use_imm      = 1'b1;
        ctrl.imm_unsigned = 1'b1;
        ctrl.kind         = K_AND;
      end
      OPC_LOAD: begin
        ctrl.reg_wr  = 1'b1;
        ctrl.wsel    = WR_TO_RT;
        ctrl.use_imm = 1'b1;
        ctrl.ld      = 1'b1;
      end
      OPC_STORE: begin
        ctrl.use_imm = 1'b1;
        ctrl.st      = 1'b1;
      end
      OPC_BR_EQ: ctrl.br_eq = 1'b1;
      OPC_BR_NE: ctrl.br_ne = 1'b1;
      OPC_CALL: begin
        ctrl.call   = 1'b1;
        ctrl.reg_wr = 1'b1;
        ctrl.wsel   = WR_TO_LINK;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/onecyc_calc.sv
module onecyc_calc
  import onecyc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  calc_e          kind,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic [4:0]     sh,
  output logic [DW-1:0]  y
);

  always_comb begin
    unique case (kind)
      K_SUB:   y = a - b;
      K_AND:   y = a & b;
      K_OR:    y = a | b;
      K_SHL:   y = b << sh;
      K_SHR:   y = b >> sh;
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/onecyc_regfile.sv
module onecyc_regfile #(
  parameter int unsigned AW  = 5,
  parameter int unsigned DW  = 32,
  parameter int unsigned NRD = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr [NRD],
  output logic [DW-1:0] rd_data [NRD],
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);

  localparam int unsigned NREG = 1 << AW;

  logic [DW-1:0] regs [NREG];
  logic          wr_live;

  assign wr_live = wr_en && (wr_addr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_live) begin
      regs[wr_addr] <= wr_data;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = (rd_addr[g] == '0) ? '0 : regs[rd_addr[g]];
  end

  // R9: entry 0 never holds a nonzero value
  assert_zero_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    regs[0] == '0);

  // R2: an accepted write is visible in the addressed entry at the next edge
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && ($past(wr_addr) != '0))
      |-> regs[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/onecyc_nextpc.sv
module onecyc_nextpc
  import onecyc_pkg::*;
(
  input  logic [XLEN-1:0] pc,
  input  logic            br_eq,
  input  logic            br_ne,
  input  logic            call,
  input  logic            ret,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic [15:0]     off,
  input  logic [25:0]     tgt,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] next_pc,
  output logic            br_taken,
  output logic            redirect
);

  logic same;

  assign seq_pc   = pc + 32'd4;
  assign same     = (rs_val == rt_val);
  assign br_taken = (br_eq && same) || (br_ne && !same);
  assign redirect = br_taken || call || ret;

  always_comb begin
    if (ret)           next_pc = rs_val;
    else if (call)     next_pc = abs_dest(seq_pc, tgt);
    else if (br_taken) next_pc = rel_dest(seq_pc, off);
    else               next_pc = seq_pc;
  end

endmodule

// File: rtl/onecyc_core.sv
module onecyc_core
  import onecyc_pkg::*;
#(
  parameter int unsigned IMEM_AW = 6,
  parameter int unsigned DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               imem_we,
  input  logic [IMEM_AW-1:0] imem_waddr,
  input  logic [31:0]        imem_wdata,
  output logic [31:0]        pc_o,
  input  logic [4:0]         dbg_reg_sel,
  output logic [31:0]        dbg_reg_val,
  input  logic [DMEM_AW-1:0] dbg_mem_sel,
  output logic [31:0]        dbg_mem_val
);

  localparam int unsigned IDEPTH = 1 << IMEM_AW;
  localparam int unsigned DDEPTH = 1 << DMEM_AW;

  logic [XLEN-1:0] imem [IDEPTH];
  logic [XLEN-1:0] dmem [DDEPTH];
  logic [XLEN-1:0] pc_q;

  logic [XLEN-1:0] instr;
  logic [4:0]      f_rs, f_rt, f_rd, f_sh;
  logic [15:0]     f_imm;
  logic [25:0]     f_tgt;
  ctrl_t           ctrl;

  logic [4:0]      rf_raddr [3];
  logic [XLEN-1:0] rf_rdata [3];
  logic [XLEN-1:0] rs_val, rt_val, imm_val, imm_signed, calc_b, calc_y, wb_data;
  logic [4:0]      wr_addr;
  logic [DMEM_AW-1:0] dm_idx;
  logic [XLEN-1:0] seq_pc, next_pc;
  logic            br_taken, redirect, is_call, is_store, wr_fire;

  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_waddr] <= imem_wdata;
  end

  assign instr = imem[pc_q[IMEM_AW+1:2]];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_sh  = instr[10:6];
  assign f_imm = instr[15:0];
  assign f_tgt = instr[25:0];

  onecyc_decode u_dec (
    .op   (instr[31:26]),
    .fn   (instr[5:0]),
    .ctrl (ctrl)
  );

  assign rf_raddr[0] = f_rs;
  assign rf_raddr[1] = f_rt;
  assign rf_raddr[2] = dbg_reg_sel;
  assign rs_val      = rf_rdata[0];
  assign rt_val      = rf_rdata[1];
  assign dbg_reg_val = rf_rdata[2];

  assign imm_signed = sext16(f_imm);
  assign imm_val    = ctrl.imm_unsigned ? zext16(f_imm) : imm_signed;
  assign calc_b     = ctrl.use_imm ? imm_val : rt_val;

  onecyc_calc #(.DW(XLEN)) u_calc (
    .kind (ctrl.kind),
    .a    (rs_val),
    .b    (calc_b),
    .sh   (f_sh),
    .y    (calc_y)
  );

  onecyc_nextpc u_npc (
    .pc       (pc_q),
    .br_eq    (ctrl.br_eq),
    .br_ne    (ctrl.br_ne),
    .call     (ctrl.call),
    .ret      (ctrl.ret),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .off      (f_imm),
    .tgt      (f_tgt),
    .seq_pc   (seq_pc),
    .next_pc  (next_pc),
    .br_taken (br_taken),
    .redirect (redirect)
  );

  assign dm_idx   = calc_y[DMEM_AW+1:2];
  assign is_call  = ctrl.call;
  assign is_store = ctrl.st;
  assign wr_fire  = ctrl.reg_wr;

  always_comb begin
    unique case (ctrl.wsel)
      WR_TO_RT:   wr_addr = f_rt;
      WR_TO_LINK: wr_addr = LINK_REG;
      default:    wr_addr = f_rd;
    endcase
  end

  always_comb begin
    if (ctrl.ld)        wb_data = dmem[dm_idx];
    else if (ctrl.call) wb_data = seq_pc;
    else                wb_data = calc_y;
  end

  onecyc_regfile #(.AW(REG_AW), .DW(XLEN), .NRD(3)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rf_raddr),
    .rd_data (rf_rdata),
    .wr_en   (wr_fire),
    .wr_addr (wr_addr),
    .wr_data (wb_data)
  );

  always_ff @(posedge clk) begin
    if (rst_n && is_store) dmem[dm_idx] <= rt_val;
  end

  assign dbg_mem_val = dmem[dbg_mem_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= next_pc;
  end

  assign pc_o = pc_q;

  // R11: straight-line instructions advance by one word per clock
  assert_seq_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(redirect)) |-> pc_q == $past(pc_q) + 32'd4);

  // R6: a taken branch lands on the word-scaled relative destination
  assert_branch_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(br_taken))
      |-> pc_q == $past(pc_q) + 32'd4 + {$past(imm_signed[29:0]), 2'b00});

  // R7: a call lands on its absolute word target
  assert_call_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(is_call)) |-> pc_q[27:0] == {$past(f_tgt), 2'b00});

  // R5: a store is visible in the addressed data word at the next edge
  assert_store_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(is_store)) |-> dmem[$past(dm_idx)] == $past(rt_val));

  // R1: the program counter sits at zero throughout reset
  assert_reset_pc_R1: assert property (@(posedge clk)
    !rst_n |-> pc_q == '0);

endmodule

// File: tb/test_onecyc_core.sv
module test_onecyc_core;

  localparam logic [5:0] T_ADDI = 6'h08, T_ANDI = 6'h0C, T_LW = 6'h23, T_SW = 6'h2B;
  localparam logic [5:0] T_BEQ = 6'h04, T_BNE = 6'h05, T_JAL = 6'h03;
  localparam logic [5:0] F_SLL = 6'h00, F_SRL = 6'h02, F_JR = 6'h08;
  localparam logic [5:0] F_ADD = 6'h20, F_SUB = 6'h22, F_AND = 6'h24, F_OR = 6'h25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_we = 1'b0;
  logic [5:0]  imem_waddr = '0;
  logic [31:0] imem_wdata = '0;
  logic [31:0] pc_o;
  logic [4:0]  dbg_reg_sel = '0;
  logic [31:0] dbg_reg_val;
  logic [5:0]  dbg_mem_sel = '0;
  logic [31:0] dbg_mem_val;

  int checks = 0;
  int errors = 0;
  logic [31:0] prog [64];
  int plen = 0;

  always #10 clk = ~clk;

  onecyc_core i_onecyc_core (
    .clk (clk), .rst_n (rst_n),
    .imem_we (imem_we), .imem_waddr (imem_waddr), .imem_wdata (imem_wdata),
    .pc_o (pc_o),
    .dbg_reg_sel (dbg_reg_sel), .dbg_reg_val (dbg_reg_val),
    .dbg_mem_sel (dbg_mem_sel), .dbg_mem_val (dbg_mem_val)
  );

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt,
                                        input int rd, input int sh);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                        input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic emit(input logic [31:0] w);
    prog[plen] = w;
    plen++;
  endtask

  task automatic emit_halt();
    emit(enc_i(T_BEQ, 0, 0, 16'hFFFF));
  endtask

  task automatic emit_const(input int r, input logic [31:0] v);
    emit(enc_i(T_ADDI, 0, r, v[31:16]));
    emit(enc_r(F_SLL, 0, r, r, 16));
    emit(enc_i(T_ADDI, 0, 30, v[15:0]));
    emit(enc_i(T_ANDI, 30, 30, 16'hFFFF));
    emit(enc_r(F_OR, r, 30, r, 0));
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input int r, input logic [31:0] exp);
    dbg_reg_sel = 5'(r);
    #1;
    check(tag, dbg_reg_val, exp);
  endtask

  task automatic start_prog();
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      imem_we    = 1'b1;
      imem_waddr = 6'(i);
      imem_wdata = (i < plen) ? prog[i] : 32'h0;
    end
    @(negedge clk);
    imem_we = 1'b0;
    rst_n   = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] vals [8];
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7FFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h1234_5678;
    vals[6] = 32'hA5A5_F00F; vals[7] = 32'h0000_0005;

    // R1: state while held in reset
    repeat (3) @(negedge clk);
    #1;
    check("R1 pc in reset", pc_o, 32'h0);
    chk_reg("R1 reg in reset", 31, 32'h0);

    // R2 R3 R4: arithmetic, logic, shift and immediate sweep
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [31:0] a, b;
        logic [4:0]  sh;
        logic [15:0] imm;
        a   = vals[i];
        b   = vals[j];
        sh  = 5'((i * 7 + j * 3) % 32);
        imm = 16'(vals[j] ^ (i * 32'h0913));
        plen = 0;
        emit_const(1, a);
        emit_const(2, b);
        emit(enc_r(F_ADD, 1, 2, 3, 0));
        emit(enc_r(F_SUB, 1, 2, 4, 0));
        emit(enc_r(F_AND, 1, 2, 5, 0));
        emit(enc_r(F_OR,  1, 2, 6, 0));
        emit(enc_r(F_SLL, 0, 2, 7, int'(sh)));
        emit(enc_r(F_SRL, 0, 2, 8, int'(sh)));
        emit(enc_i(T_ADDI, 1, 9, imm));
        emit(enc_i(T_ANDI, 1, 10, imm));
        emit_halt();
        start_prog();
        repeat (40) @(negedge clk);
        chk_reg("R2 add", 3, a + b);
        chk_reg("R2 sub", 4, a - b);
        chk_reg("R2 and", 5, a & b);
        chk_reg("R2 or", 6, a | b);
        chk_reg("R3 shift left", 7, b << sh);
        chk_reg("R3 shift right", 8, b >> sh);
        chk_reg("R4 addi sign-extended", 9, a + {{16{imm[15]}}, imm});
        chk_reg("R4 andi zero-extended", 10, a & {16'h0000, imm});
      end
    end

    // R1: reset clears every register after a populated run
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    check("R1 pc cleared", pc_o, 32'h0);
    for (int r = 0; r < 32; r++) chk_reg("R1 reg cleared", r, 32'h0);

    // R11 R10 R9: straight-line stepping, unknown codes, register 0
    plen = 0;
    emit(enc_i(T_ADDI, 0, 1, 16'd1));
    emit(enc_i(T_ADDI, 0, 2, 16'd2));
    emit(enc_i(6'h3F, 0, 20, 16'h0055));
    emit(enc_r(6'h3E, 1, 2, 21, 0));
    emit(enc_i(T_ADDI, 0, 0, 16'd5));
    emit(enc_i(T_ADDI, 0, 23, 16'd9));
    emit(enc_r(F_ADD, 0, 23, 22, 0));
    emit(enc_r(F_ADD, 1, 2, 24, 0));
    emit_halt();
    start_prog();
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      #1;
      check("R11 pc step", pc_o, 32'(4 * k));
    end
    repeat (3) @(negedge clk);
    #1;
    check("R6 halt parks pc", pc_o, 32'd32);
    chk_reg("R10 unknown opcode no write", 20, 32'h0);
    chk_reg("R10 unknown function no write", 21, 32'h0);
    chk_reg("R9 reg0 reads zero", 0, 32'h0);
    chk_reg("R9 reg0 write discarded", 22, 32'd9);
    chk_reg("R11 final sum", 24, 32'd3);

    // R5: store then load through signed offsets
    for (int bi = 0; bi < 2; bi++) begin
      for (int oi = 0; oi < 3; oi++) begin
        int base, off, idx;
        logic [31:0] v;
        base = (bi == 0) ? 40 : 100;
        off  = (oi == 0) ? -8 : ((oi == 1) ? 0 : 12);
        idx  = (base + off) / 4;
        v    = 32'hC0DE_1234 + 32'(base * 977) + 32'(off);
        plen = 0;
        emit(enc_i(T_ADDI, 0, 2, 16'(base)));
        emit_const(1, v);
        emit(enc_i(T_SW, 2, 1, 16'(off)));
        emit(enc_i(T_LW, 2, 11, 16'(off)));
        emit_halt();
        start_prog();
        repeat (20) @(negedge clk);
        chk_reg("R5 load returns stored word", 11, v);
        dbg_mem_sel = 6'(idx);
        #1;
        check("R5 data word after store", dbg_mem_val, v);
      end
    end

    // R6: forward branches taken and not taken
    for (int p = 0; p < 4; p++) begin
      for (int ne = 0; ne < 2; ne++) begin
        logic [15:0] x, y;
        logic taken;
        x = (p == 0) ? 16'd3 : ((p == 1) ? 16'd3 : ((p == 2) ? 16'hFFFE : 16'd0));
        y = (p == 0) ? 16'd3 : ((p == 1) ? 16'd4 : ((p == 2) ? 16'hFFFE : 16'd7));
        taken = (ne == 0) ? (x == y) : (x != y);
        plen = 0;
        emit(enc_i(T_ADDI, 0, 1, x));
        emit(enc_i(T_ADDI, 0, 2, y));
        emit(enc_i((ne == 0) ? T_BEQ : T_BNE, 1, 2, 16'd2));
        emit(enc_i(T_ADDI, 0, 3, 16'd1));
        emit(enc_i(T_ADDI, 0, 4, 16'd1));
        emit(enc_i(T_ADDI, 0, 5, 16'd1));
        emit_halt();
        start_prog();
        repeat (12) @(negedge clk);
        chk_reg("R6 skipped slot one", 3, taken ? 32'h0 : 32'h1);
        chk_reg("R6 skipped slot two", 4, taken ? 32'h0 : 32'h1);
        chk_reg("R6 landing slot", 5, 32'h1);
      end
    end

    // R6: backward branch loop
    for (int n = 1; n <= 5; n += 2) begin
      plen = 0;
      emit(enc_i(T_ADDI, 0, 1, 16'(n)));
      emit(enc_i(T_ADDI, 2, 2, 16'd3));
      emit(enc_i(T_ADDI, 1, 1, 16'hFFFF));
      emit(enc_i(T_BNE, 1, 0, 16'hFFFD));
      emit_halt();
      start_prog();
      repeat (30) @(negedge clk);
      chk_reg("R6 loop total", 2, 32'(3 * n));
      #1;
      check("R6 loop exit pc", pc_o, 32'd16);
    end

    // R7 R8: call to an absolute word, then return through the link register
    plen = 0;
    emit({T_JAL, 26'd5});
    emit(enc_i(T_ADDI, 0, 6, 16'd7));
    emit_halt();
    emit(enc_i(T_ADDI, 0, 8, 16'd1));
    emit(enc_i(T_ADDI, 0, 8, 16'd1));
    emit(enc_i(T_ADDI, 0, 7, 16'd9));
    emit(enc_r(F_JR, 31, 0, 0, 0));
    emit(enc_i(T_ADDI, 0, 8, 16'd1));
    emit_halt();
    start_prog();
    @(negedge clk); #1;
    check("R7 call destination", pc_o, 32'd20);
    @(negedge clk); #1;
    check("R11 step inside callee", pc_o, 32'd24);
    @(negedge clk); #1;
    check("R8 return destination", pc_o, 32'd4);
    repeat (4) @(negedge clk);
    chk_reg("R7 link value", 31, 32'd4);
    chk_reg("R7 callee ran", 7, 32'd9);
    chk_reg("R8 resumed after call", 6, 32'd7);
    chk_reg("R7 skipped words untouched", 8, 32'h0);
    #1;
    check("R8 parked pc", pc_o, 32'd8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule